// File: doc/BRIEF.md
# Rectangle Fill and Vertical Scroll Engine

This block is a small 2D drawing engine for a 32-bit-per-pixel framebuffer. Software loads a handful of parameter registers through a single write port: an operation code, a base corner, a destination corner, a height and a width. Two further registers hold the foreground colour and the raster operation code. Writing the width register launches the operation. The engine then walks the rectangle one pixel at a time and raises `busy` until the last pixel has been stored.

Two operations are supported. A solid fill combines the foreground colour with each pixel of the rectangle under one of three raster operations. Two of them need the old pixel, so those fills become read-modify-write. A vertical scroll copies a block of rows to a different row position in the same columns. It reads every source pixel and writes it to the destination, and it walks bottom-to-top when it moves data downward, so overlapping blocks copy correctly.

Pixel addresses follow a fixed line pitch of 8192 bytes. At 4 bytes per pixel, that is 2048 pixels per line. The framebuffer is a synchronous memory model inside the block with a one-cycle read latency. A combinational debug read port exposes its contents. A pixel word packs blue in bits 23:16, green in bits 15:8 and red in bits 7:0, and the engine treats the word as opaque data.

Top module: `rect_fill_engine`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `busy` is low.
- R2: A write (`reg_we` high) stores `reg_wdata` into the register picked by `reg_sel` only when `busy` is low, and a write presented while `busy` is high is dropped with no effect. The register selects are:
  - 0: opcode, bits 7:0
  - 1: base Y
  - 2: base X
  - 3: destination Y
  - 4: destination X
  - 5: height
  - 6: width, which also acts as the trigger
  - 7: foreground colour, 32 bits
  - 8: raster operation code, bits 7:0
- R3: An accepted write to the width register (select 6) raises `busy` in the next cycle.
- R4: Opcode 0x08 fills rows base Y to base Y + height - 1 and columns base X to base X + width - 1. Pixel (y, x) lives at word address y*2048 + x, which is `{y, x}` with x in the low 11 bits.
- R5: For a fill, raster code 0x83 stores the foreground colour. Any code other than 0x85 and 0x86 behaves as 0x83.
- R6: For a fill, raster code 0x85 leaves every pixel of the rectangle unchanged.
- R7: For a fill, raster code 0x86 stores the foreground colour XOR the old pixel.
- R8: Opcode 0x0b copies the height x width block at (base Y, base X) to (destination Y, base X), and the raster code has no effect on the copy.
- R9: A scroll whose source and destination blocks overlap leaves the destination equal to the source as it was before the scroll. Rows are processed bottom-to-top when destination Y is greater than base Y.
- R10: A scroll whose destination X differs from base X writes no pixel.
- R11: A zero height, a zero width, or an opcode other than 0x08 and 0x0b writes no pixel, and `busy` stays high for exactly one cycle.
- R12: The engine makes one memory access per cycle, and each read is followed in the next cycle by its write. `busy` lasts N+1 cycles for an N-pixel fill with codes 0x83 or unknown, and 2N+1 cycles for fills with 0x85 or 0x86 and for scrolls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Operation in progress; register writes are dropped while high |
| dbg_addr | input | 22 | Framebuffer word address for the debug read |
| dbg_data | output | 32 | Framebuffer word at `dbg_addr` |

## Verification
The bench first loads a distinct value into every modelled pixel. It then sweeps fills over many corners and sizes under each raster code, and checks every pixel of the framebuffer against an arithmetic model after each operation. A wrong pitch or column offset would smear pixels outside the rectangle. An XOR or keep-old operation that skipped the read would store stale or foreground data.

Scrolls are swept over every destination row, above and below the source, including overlapping moves. The bench compares them against a snapshot copy, so a top-to-bottom walk on a downward move would propagate the first source row down the block. It also checks the following:
- Mismatched columns, zero sizes and unknown opcodes must leave the framebuffer intact and hold `busy` for one cycle.
- Writes arriving while busy must not change the colour or restart the engine.
- The busy duration is checked against the one-access-per-cycle count, which exposes a lost or extra cycle.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam logic [7:0] OP_FILL   = 8'h08;
  localparam logic [7:0] OP_SCROLL = 8'h0b;

  localparam logic [7:0] ROP_NEW = 8'h83;
  localparam logic [7:0] ROP_OLD = 8'h85;
  localparam logic [7:0] ROP_XOR = 8'h86;

  localparam logic [3:0] SEL_OPC = 4'd0;
  localparam logic [3:0] SEL_BY  = 4'd1;
  localparam logic [3:0] SEL_BX  = 4'd2;
  localparam logic [3:0] SEL_DY  = 4'd3;
  localparam logic [3:0] SEL_DX  = 4'd4;
  localparam logic [3:0] SEL_H   = 4'd5;
  localparam logic [3:0] SEL_W   = 4'd6;
  localparam logic [3:0] SEL_FG  = 4'd7;
  localparam logic [3:0] SEL_ROP = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } walk_st_t;
endpackage

// File: rtl/rfe_regs.sv
module rfe_regs
  import rfe_pkg::*;
#(
  parameter int X_W   = 11,
  parameter int Y_W   = 11,
  parameter int LEN_W = 12,
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_sel,
  input  logic [PIX_W-1:0] reg_wdata,
  input  logic             busy_i,
  output logic [7:0]       opc_q,
  output logic [Y_W-1:0]   by_q,
  output logic [X_W-1:0]   bx_q,
  output logic [Y_W-1:0]   dy_q,
  output logic [X_W-1:0]   dx_q,
  output logic [LEN_W-1:0] h_q,
  output logic [LEN_W-1:0] w_q,
  output logic [PIX_W-1:0] fg_q,
  output logic [7:0]       rop_q,
  output logic             start_q
);
  logic             acc;
  logic [7:0]       opc_d, rop_d;
  logic [Y_W-1:0]   by_d, dy_d;
  logic [X_W-1:0]   bx_d, dx_d;
  logic [LEN_W-1:0] h_d, w_d;
  logic [PIX_W-1:0] fg_d;
  logic             start_d;

  assign acc = reg_we && !busy_i;

  always_comb begin
    opc_d   = opc_q;
    by_d    = by_q;
    bx_d    = bx_q;
    dy_d    = dy_q;
    dx_d    = dx_q;
    h_d     = h_q;
    w_d     = w_q;
    fg_d    = fg_q;
    rop_d   = rop_q;
    start_d = 1'b0;
    if (acc) begin
      case (reg_sel)
        SEL_OPC: opc_d = reg_wdata[7:0];
        SEL_BY:  by_d  = reg_wdata[Y_W-1:0];
        SEL_BX:  bx_d  = reg_wdata[X_W-1:0];
        SEL_DY:  dy_d  = reg_wdata[Y_W-1:0];
        SEL_DX:  dx_d  = reg_wdata[X_W-1:0];
        SEL_H:   h_d   = reg_wdata[LEN_W-1:0];
        SEL_W: begin
          w_d     = reg_wdata[LEN_W-1:0];
          start_d = 1'b1;
        end
        SEL_FG:  fg_d  = reg_wdata;
        SEL_ROP: rop_d = reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q   <= '0;
      by_q    <= '0;
      bx_q    <= '0;
      dy_q    <= '0;
      dx_q    <= '0;
      h_q     <= '0;
      w_q     <= '0;
      fg_q    <= '0;
      rop_q   <= ROP_NEW;
      start_q <= 1'b0;
    end else begin
      opc_q   <= opc_d;
      by_q    <= by_d;
      bx_q    <= bx_d;
      dy_q    <= dy_d;
      dx_q    <= dx_d;
      h_q     <= h_d;
      w_q     <= w_d;
      fg_q    <= fg_d;
      rop_q   <= rop_d;
      start_q <= start_d;
    end
  end

  // R2
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy_i) |=> ($stable(fg_q) && $stable(w_q) && $stable(opc_q) && !start_q));
endmodule

// File: rtl/rfe_rop.sv
module rfe_rop
  import rfe_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic [7:0]       rop,
  input  logic [PIX_W-1:0] fg,
  input  logic [PIX_W-1:0] old_pix,
  output logic [PIX_W-1:0] new_pix
);
  always_comb begin
    case (rop)
      ROP_OLD: new_pix = old_pix;
      ROP_XOR: new_pix = fg ^ old_pix;
      default: new_pix = fg;
    endcase
  end
endmodule

// File: rtl/rfe_fbmem.sv
module rfe_fbmem #(
  parameter int X_W     = 11,
  parameter int Y_W     = 11,
  parameter int FB_ROWS = 8,
  parameter int FB_COLS = 16,
  parameter int PIX_W   = 32,
  localparam int ADDR_W = X_W + Y_W,
  localparam int ROW_B  = $clog2(FB_ROWS),
  localparam int COL_B  = $clog2(FB_COLS),
  localparam int DEPTH  = FB_ROWS * FB_COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIX_W-1:0]  wdata,
  output logic [PIX_W-1:0]  rdata,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [PIX_W-1:0]  dbg_data
);
  localparam logic [Y_W-1:0] ROWS_L = Y_W'(FB_ROWS);
  localparam logic [X_W-1:0] COLS_L = X_W'(FB_COLS);

  logic [PIX_W-1:0] mem [DEPTH];
  logic             hit, dbg_hit;
  logic [ROW_B+COL_B-1:0] idx, dbg_idx;
  logic [PIX_W-1:0] rdata_d;

  assign hit     = (addr[ADDR_W-1:X_W] < ROWS_L) && (addr[X_W-1:0] < COLS_L);
  assign dbg_hit = (dbg_addr[ADDR_W-1:X_W] < ROWS_L) && (dbg_addr[X_W-1:0] < COLS_L);
  assign idx     = {addr[X_W +: ROW_B], addr[COL_B-1:0]};
  assign dbg_idx = {dbg_addr[X_W +: ROW_B], dbg_addr[COL_B-1:0]};

  assign dbg_data = dbg_hit ? mem[dbg_idx] : '0;
  assign rdata_d  = (en && !we && hit) ? mem[idx] : rdata;

  always_ff @(posedge clk) begin
    if (en && we && hit) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
  import rfe_pkg::*;
#(
  parameter int X_W   = 11,
  parameter int Y_W   = 11,
  parameter int LEN_W = 12,
  parameter int PIX_W = 32,
  localparam int ADDR_W = X_W + Y_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opc,
  input  logic [Y_W-1:0]    base_y,
  input  logic [X_W-1:0]    base_x,
  input  logic [Y_W-1:0]    dst_y,
  input  logic [X_W-1:0]    dst_x,
  input  logic [LEN_W-1:0]  h_len,
  input  logic [LEN_W-1:0]  w_len,
  input  logic [PIX_W-1:0]  fg,
  input  logic [7:0]        rop,
  input  logic [PIX_W-1:0]  rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              active
);
  walk_st_t         st_q, st_d;
  logic [LEN_W-1:0] col_q, col_d, row_q, row_d;
  logic             is_fill, is_scroll, op_ok, need_rd, rev;
  logic             last_col, last_row;
  logic [Y_W-1:0]   row_idx, src_y, wr_y;
  logic [X_W-1:0]   col_x;
  logic [PIX_W-1:0] rop_pix;

  assign is_fill   = (opc == OP_FILL);
  assign is_scroll = (opc == OP_SCROLL);
  assign op_ok     = (is_fill || (is_scroll && (dst_x == base_x)))
                     && (h_len != '0) && (w_len != '0);
  assign need_rd   = is_scroll || (rop == ROP_OLD) || (rop == ROP_XOR);
  assign rev       = is_scroll && (dst_y > base_y);

  assign last_col = (col_q == w_len - LEN_W'(1));
  assign last_row = (row_q == h_len - LEN_W'(1));

  assign row_idx = rev ? (h_len[Y_W-1:0] - Y_W'(1) - row_q[Y_W-1:0]) : row_q[Y_W-1:0];
  assign src_y   = base_y + row_idx;
  assign wr_y    = (is_scroll ? dst_y : base_y) + row_idx;
  assign col_x   = base_x + col_q[X_W-1:0];

  rfe_rop #(.PIX_W(PIX_W)) u_rop (
    .rop     (rop),
    .fg      (fg),
    .old_pix (rdata),
    .new_pix (rop_pix)
  );

  assign mem_en    = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_RD) ? {src_y, col_x} : {wr_y, col_x};
  assign mem_wdata = is_scroll ? rdata : rop_pix;
  assign active    = (st_q != ST_IDLE);

  always_comb begin
    st_d  = st_q;
    col_d = col_q;
    row_d = row_q;
    case (st_q)
      ST_IDLE: begin
        if (start && op_ok) begin
          st_d  = need_rd ? ST_RD : ST_WR;
          col_d = '0;
          row_d = '0;
        end
      end
      ST_RD: st_d = ST_WR;
      ST_WR: begin
        if (last_col) begin
          col_d = '0;
          row_d = row_q + LEN_W'(1);
        end else begin
          col_d = col_q + LEN_W'(1);
        end
        if (last_col && last_row) begin
          st_d = ST_IDLE;
        end else begin
          st_d = need_rd ? ST_RD : ST_WR;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      col_q <= '0;
      row_q <= '0;
    end else begin
      st_q  <= st_d;
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // R12
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we));

  // R11
  null_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active && (h_len == '0 || w_len == '0)) |=> !mem_en);

  // R10
  col_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active && is_scroll && (dst_x != base_x)) |=> !mem_en);
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int PITCH_BYTES   = 8192,
  parameter int BYTES_PER_PIX = 4,
  parameter int Y_W           = 11,
  parameter int FB_ROWS       = 8,
  parameter int FB_COLS       = 16,
  parameter int PIX_W         = 32,
  localparam int X_W    = $clog2(PITCH_BYTES / BYTES_PER_PIX),
  localparam int ADDR_W = X_W + Y_W,
  localparam int LEN_W  = ((X_W > Y_W) ? X_W : Y_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_sel,
  input  logic [PIX_W-1:0]  reg_wdata,
  output logic              busy,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [PIX_W-1:0]  dbg_data
);
  logic [7:0]        opc, rop;
  logic [Y_W-1:0]    by, dy;
  logic [X_W-1:0]    bx, dx;
  logic [LEN_W-1:0]  h_len, w_len;
  logic [PIX_W-1:0]  fg, rdata, wdata;
  logic              start, active, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;

  assign busy = start || active;

  rfe_regs #(.X_W(X_W), .Y_W(Y_W), .LEN_W(LEN_W), .PIX_W(PIX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy_i(busy),
    .opc_q(opc), .by_q(by), .bx_q(bx), .dy_q(dy), .dx_q(dx),
    .h_q(h_len), .w_q(w_len), .fg_q(fg), .rop_q(rop), .start_q(start)
  );

  rfe_walker #(.X_W(X_W), .Y_W(Y_W), .LEN_W(LEN_W), .PIX_W(PIX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .opc(opc),
    .base_y(by), .base_x(bx), .dst_y(dy), .dst_x(dx),
    .h_len(h_len), .w_len(w_len), .fg(fg), .rop(rop), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(wdata), .active(active)
  );

  rfe_fbmem #(.X_W(X_W), .Y_W(Y_W), .FB_ROWS(FB_ROWS), .FB_COLS(FB_COLS),
              .PIX_W(PIX_W)) u_fb (
    .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(wdata), .rdata(rdata), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  // R3
  trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_sel == SEL_W) && !busy) |=> busy);

  // R1
  idle_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);
endmodule

// File: tb/rect_fill_engine_tb.sv
module rect_fill_engine_tb;
  import rfe_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        busy;
  logic [21:0] dbg_addr;
  logic [31:0] dbg_data;

  int vec_cnt = 0;
  int bad_cnt = 0;
  logic [31:0] fbm [8][16];

  rect_fill_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic launch(input logic [7:0] op, input int by, input int bx,
                        input int dy, input int dx, input int h, input int w,
                        output int cyc);
    wr(SEL_OPC, 32'(op)); wr(SEL_BY, 32'(by)); wr(SEL_BX, 32'(bx));
    wr(SEL_DY, 32'(dy));  wr(SEL_DX, 32'(dx)); wr(SEL_H, 32'(h));
    wr(SEL_W, 32'(w));
    wait_idle(cyc);
  endtask

  task automatic check_fb(input string req);
    for (int y = 0; y < 8; y++) begin
      for (int x = 0; x < 16; x++) begin
        dbg_addr = {11'(y), 11'(x)};
        #1;
        chk(dbg_data === fbm[y][x], req, $sformatf("pixel y=%0d x=%0d", y, x),
            dbg_data, fbm[y][x]);
      end
    end
  endtask

  task automatic do_fill(input int x, input int y, input int w, input int h,
                         input logic [31:0] fg, input logic [7:0] rop,
                         input string req, input bit full_chk);
    int cyc, n, exp_cyc;
    wr(SEL_FG, fg);
    wr(SEL_ROP, 32'(rop));
    launch(OP_FILL, y, x, 0, 0, h, w, cyc);
    n = w * h;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        case (rop)
          ROP_OLD: ;
          ROP_XOR: fbm[y+r][x+c] = fg ^ fbm[y+r][x+c];
          default: fbm[y+r][x+c] = fg;
        endcase
      end
    end
    if (n == 0) exp_cyc = 1;
    else if (rop == ROP_OLD || rop == ROP_XOR) exp_cyc = 2 * n + 1;
    else exp_cyc = n + 1;
    chk(cyc == exp_cyc, "R12", "fill busy cycles", 32'(cyc), 32'(exp_cyc));
    if (full_chk) check_fb(req);
  endtask

  task automatic do_scroll(input int sy, input int x, input int dy, input int dx,
                           input int h, input int w, input string req);
    int cyc, exp_cyc;
    logic [31:0] snap [8][16];
    launch(OP_SCROLL, sy, x, dy, dx, h, w, cyc);
    snap = fbm;
    if (dx == x && h > 0 && w > 0) begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          fbm[dy+r][x+c] = snap[sy+r][x+c];
      exp_cyc = 2 * h * w + 1;
    end else begin
      exp_cyc = 1;
    end
    chk(cyc == exp_cyc, "R12", "scroll busy cycles", 32'(cyc), 32'(exp_cyc));
    check_fb(req);
  endtask

  task automatic load_pattern();
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 16; x++)
        do_fill(x, y, 1, 1, 32'h00_40_00_05 | 32'(y << 12) | 32'(x << 4), ROP_NEW, "R4", 1'b0);
    check_fb("R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad_cnt++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] rops [4];
    string tags [4];
    rops[0] = ROP_NEW; rops[1] = ROP_OLD; rops[2] = ROP_XOR; rops[3] = 8'h3c;
    tags[0] = "R5";    tags[1] = "R6";    tags[2] = "R7";    tags[3] = "R5";

    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; dbg_addr = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);

    load_pattern();

    // R5 R6 R7 R4: sweep corners and sizes under each raster code
    for (int k = 0; k < 4; k++)
      for (int y0 = 0; y0 < 3; y0++)
        for (int xi = 0; xi < 2; xi++)
          for (int wi = 0; wi < 2; wi++)
            for (int hi = 0; hi < 2; hi++)
              do_fill(xi * 5, y0, wi ? 4 : 1, hi ? 3 : 1,
                      {rops[k], 8'(y0 * 7 + 1), 8'(xi * 16 + wi * 4 + hi), 8'h5a},
                      rops[k], tags[k], 1'b1);
    do_fill(12, 5, 4, 3, 32'h00_12_34_56, ROP_NEW, "R4", 1'b1);
    do_fill(0, 0, 16, 8, 32'h0f_0f_0f_0f, ROP_XOR, "R7", 1'b1);

    // R8 R9: scrolls up and down including overlap; raster code set to XOR is ignored
    load_pattern();
    wr(SEL_ROP, 32'(ROP_XOR));
    for (int d = 0; d < 6; d++) begin
      do_scroll(2, 2, d, 2, 3, 5, (d > 2) ? "R9" : "R8");
      load_pattern();
      wr(SEL_ROP, 32'(ROP_XOR));
    end
    do_scroll(1, 0, 3, 0, 5, 16, "R9");
    do_scroll(3, 0, 0, 0, 5, 16, "R9");

    // R10: column mismatch
    do_scroll(0, 3, 4, 4, 2, 3, "R10");

    // R11: null operations
    do_fill(2, 2, 0, 3, 32'hdead_beef, ROP_NEW, "R11", 1'b1);
    do_fill(2, 2, 3, 0, 32'hdead_beef, ROP_NEW, "R11", 1'b1);
    launch(8'h09, 1, 1, 0, 0, 2, 2, cyc);
    chk(cyc == 1, "R11", "unknown opcode busy cycles", 32'(cyc), 1);
    check_fb("R11");

    // R2 R3: writes during busy are dropped
    wr(SEL_FG, 32'haaaa_5555);
    wr(SEL_ROP, 32'(ROP_NEW));
    wr(SEL_OPC, 32'(OP_FILL)); wr(SEL_BY, 0); wr(SEL_BX, 0);
    wr(SEL_H, 8);
    wr(SEL_W, 16);
    chk(busy == 1'b1, "R3", "busy after width write", 32'(busy), 1);
    wr(SEL_FG, 32'h1234_0000);
    wr(SEL_W, 1);
    wait_idle(cyc);
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 16; x++)
        fbm[y][x] = 32'haaaa_5555;
    @(negedge clk);
    chk(busy == 1'b0, "R2", "no restart from dropped width write", 32'(busy), 0);
    check_fb("R2");
    wr(SEL_H, 1);
    wr(SEL_W, 1);
    wait_idle(cyc);
    chk(cyc == 2, "R12", "1x1 fill busy cycles", 32'(cyc), 2);
    dbg_addr = '0;
    #1;
    chk(dbg_data == 32'haaaa_5555, "R2", "colour kept after dropped write",
        dbg_data, 32'haaaa_5555);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule